// File: doc/BRIEF.md
# Clock Generator Control Register Slave

This block is the two-wire serial slave of a multi-output clock generator. A host writes a run of control bytes into a small register bank and reads the bank back. The bank's bits drive the clock gating and configuration logic next to it: output enables, stop behaviour of the CPU and PCI outputs, spread settings, the mode of the dual-function output, edge and delay trims, and a pair of divider values. The SCL and SDA lines are sampled on the system clock. The slave pulls SDA low through a single output-enable signal.

A write transaction has four parts in this order: the write address, a command byte whose value is ignored, a byte count, and then data bytes. The data bytes fill the bank starting at index 0, one index per byte. A read transaction has the read address followed by the bank contents, again starting at index 0. Some bits of the bank are not storage. They show the live level of input pins. Byte 6 is a fixed signature. The divider values only reach the working divider outputs while a gate bit is open.

Top module: `clkgen_ctrl_slave`

## Requirements
- R1: Only the address byte 0xD2 (write) and the address byte 0xD3 (read) are acknowledged. Any other address byte is not acknowledged, and the rest of that transaction changes nothing.
- R2: In a write, the byte after the address is acknowledged and its value is ignored. The next byte is the count. Data bytes then go to indices 0, 1, 2 and onward in order. Data bytes aimed at indices 10 and above are acknowledged and have no effect.
- R3: Data bytes beyond the count are not acknowledged and are not stored. The slave then stays silent until the next START.
- R4: A read returns bytes from index 0 upward, MSB first, for as long as the master acknowledges. Indices 10 and above read 0x00. A master NACK ends the transfer.
- R5: Byte 0 layout. Bit 7 drives spread_en and bit 5 drives aux_48m_sel (0 selects 66 MHz). Bit 4 reads the live cpu_stop_pin_n. Bits 2..0 read the live fsel_pin. Bits 4, 2, 1 and 0 are read-only. Bit 6 is plain storage.
- R6: Byte 0 bit 3 holds a soft PCI run bit that resets to 1. Reading bit 3 returns that bit ANDed with pci_stop_pin_n. The pci_run output is the same AND.
- R7: Byte 1 layout. Bit 7 reads the live mult_pin and is read-only. Bits 5..3 drive cpu_freerun[2:0]. Bits 2..0 drive cpu_en[2:0]. Reset value: 0x07.
- R8: Byte 2 layout. Bits 6..0 drive pci_en (reset 0x7F). Byte 3 layout: bit 7 drives dot48_en, bit 6 drives usb48_en, bits 5..3 drive fpci_stoppable and bits 2..0 drive fpci_en (reset 0xC7). Byte 4 layout: bit 7 drives spread_center and bits 5..0 drive clk66_en. Byte 5 layout: bits 7..6 drive spread_sel, bits 5..4 drive delay_sel, and bits 2 and 0 drive edge_slow[1] and edge_slow[0].
- R9: Byte 6 always reads 0x03. A write to byte 6 is acknowledged and discarded.
- R10: Byte 8 is the N value and byte 9 bits 7..1 are the R value. While byte 9 bit 0 is 1, div_n and div_r follow them on every clock. While it is 0, div_n and div_r hold.
- R11: Reset values. Byte 0 stores 0x08, byte 4 is 0x3F, byte 5 is 0x40, and bytes 7, 8 and 9 are 0x00. div_n and div_r reset to 0. Every register keeps its value until the next reset.
- R12: A START at any point, including in the middle of a byte, abandons the current transaction and begins a new address phase. A STOP returns the slave to idle. A partly received byte is never stored.
- R13: Both lines pass through a two-flop synchronizer. sda_oe rises only after SCL has been sampled low. It falls only after SCL has been sampled low or after a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| cpu_stop_pin_n | input | 1 | CPU stop pin, shown in byte 0 bit 4 |
| pci_stop_pin_n | input | 1 | PCI stop pin, ANDed into pci_run |
| fsel_pin | input | 3 | Frequency select pins, shown in byte 0 bits 2..0 |
| mult_pin | input | 1 | Current multiplier pin, shown in byte 1 bit 7 |
| spread_en | output | 1 | Spread enable |
| spread_center | output | 1 | Center-spread mode |
| spread_sel | output | 2 | Spread amount select |
| aux_48m_sel | output | 1 | Dual-function output selects 48 MHz |
| pci_run | output | 1 | PCI run, AND of pin and soft bit |
| cpu_freerun | output | 3 | CPU outputs that keep running under stop |
| cpu_en | output | 3 | CPU output enables |
| pci_en | output | 7 | PCI output enables |
| dot48_en | output | 1 | 48 MHz dot output enable |
| usb48_en | output | 1 | 48 MHz USB output enable |
| fpci_stoppable | output | 3 | Free PCI outputs made stoppable |
| fpci_en | output | 3 | Free PCI output enables |
| clk66_en | output | 6 | 66 MHz output enables |
| delay_sel | output | 2 | Input-to-output delay trim |
| edge_slow | output | 2 | Slow edge select {dot, usb} |
| div_n | output | 8 | Working N divider value |
| div_r | output | 7 | Working R divider value |

## Verification
The hardest states to reach from the pins are inside a transaction. Examples are a START or STOP that arrives partway through a byte, data bytes that run past the announced count, and a gate bit that opens and closes within a single write. In that last case div_n must follow byte 8 only for as long as the gate stays open. A bit-level bus master in the bench produces these cases directly. It cuts bytes short, sends more data than the count allows, and orders the gate and divider bytes inside one write. A byte-accurate model of the bank then gives the expected acknowledges, readback and outputs for both the directed cases and the seeded random writes.

// File: rtl/clkgen_ctrl_pkg.sv
package clkgen_ctrl_pkg;

  localparam int NUM_REGS  = 10;
  localparam int IDX_CTL0  = 0;
  localparam int IDX_CTL1  = 1;
  localparam int IDX_SIG   = 6;
  localparam int IDX_DIVN  = 8;
  localparam int IDX_DIVR  = 9;
  localparam logic [7:0] SIG_VALUE = 8'h03;

  typedef enum logic [2:0] {
    LS_IDLE, LS_RX, LS_RACK, LS_TX, LS_MACK, LS_WAIT
  } link_state_t;

  typedef enum logic [1:0] {
    PH_ADDR, PH_CMD, PH_CNT, PH_DATA
  } rx_phase_t;

  function automatic logic [7:0] reg_reset(int unsigned i);
    case (i)
      0:       return 8'h08;
      1:       return 8'h07;
      2:       return 8'h7F;
      3:       return 8'hC7;
      4:       return 8'h3F;
      5:       return 8'h40;
      6:       return SIG_VALUE;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] reg_wmask(int unsigned i);
    case (i)
      0:       return 8'hE8;
      1:       return 8'h7F;
      6:       return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/clkgen_bus_sync.sv
module clkgen_bus_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[s] <= '1;
          else        pipe[s] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[s] <= '1;
          else        pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/clkgen_smb_link.sv
module clkgen_smb_link
  import clkgen_ctrl_pkg::*;
#(
  parameter logic [6:0] BUS_ADDR = 7'h69,
  parameter int         IDXW     = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_s,
  input  logic            sda_s,
  input  logic [7:0]      rd_data,
  output logic            sda_oe,
  output logic [IDXW-1:0] reg_idx,
  output logic            wr_en,
  output logic [7:0]      wr_data
);

  localparam logic [IDXW-1:0] IDX_MAX = {IDXW{1'b1}};

  link_state_t     state, state_n;
  rx_phase_t       phase, phase_n;
  logic [3:0]      bit_cnt, bit_cnt_n;
  logic [7:0]      shreg, shreg_n;
  logic            is_read, is_read_n;
  logic [7:0]      cnt, cnt_n;
  logic [7:0]      data_cnt, data_cnt_n;
  logic [IDXW-1:0] idx, idx_n;
  logic            oe, oe_n;
  logic            mack, mack_n;
  logic            scl_p, sda_p;
  logic            ack_now;

  logic scl_rise, scl_fall, start_ev, stop_ev, byte_done;
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_ev  = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev   = scl_s & scl_p & ~sda_p & sda_s;
  assign byte_done = (state == LS_RX) && scl_fall && (bit_cnt == 4'd8);

  always_comb begin
    state_n    = state;
    phase_n    = phase;
    bit_cnt_n  = bit_cnt;
    shreg_n    = shreg;
    is_read_n  = is_read;
    cnt_n      = cnt;
    data_cnt_n = data_cnt;
    idx_n      = idx;
    oe_n       = oe;
    mack_n     = mack;
    wr_en      = 1'b0;
    ack_now    = 1'b0;
    if (start_ev) begin
      state_n   = LS_RX;
      phase_n   = PH_ADDR;
      bit_cnt_n = 4'd0;
      oe_n      = 1'b0;
    end else if (stop_ev) begin
      state_n = LS_IDLE;
      oe_n    = 1'b0;
    end else begin
      case (state)
        LS_RX: begin
          if (scl_rise && bit_cnt != 4'd8) begin
            shreg_n   = {shreg[6:0], sda_s};
            bit_cnt_n = bit_cnt + 4'd1;
          end else if (byte_done) begin
            case (phase)
              PH_ADDR: begin
                if (shreg[7:1] == BUS_ADDR) begin
                  ack_now   = 1'b1;
                  is_read_n = shreg[0];
                  idx_n     = '0;
                end
              end
              PH_CMD: ack_now = 1'b1;
              PH_CNT: begin
                ack_now    = 1'b1;
                cnt_n      = shreg;
                data_cnt_n = 8'd0;
              end
              default: begin
                if (data_cnt < cnt) begin
                  ack_now    = 1'b1;
                  wr_en      = 1'b1;
                  data_cnt_n = data_cnt + 8'd1;
                  if (idx != IDX_MAX) idx_n = idx + 1'b1;
                end
              end
            endcase
            if (ack_now) begin
              state_n = LS_RACK;
              oe_n    = 1'b1;
            end else begin
              state_n = LS_WAIT;
            end
          end
        end
        LS_RACK: begin
          if (scl_fall) begin
            if (phase == PH_ADDR && is_read) begin
              state_n   = LS_TX;
              shreg_n   = {rd_data[6:0], 1'b0};
              oe_n      = ~rd_data[7];
              bit_cnt_n = 4'd1;
            end else begin
              state_n   = LS_RX;
              oe_n      = 1'b0;
              bit_cnt_n = 4'd0;
              case (phase)
                PH_ADDR: phase_n = PH_CMD;
                PH_CMD:  phase_n = PH_CNT;
                default: phase_n = PH_DATA;
              endcase
            end
          end
        end
        LS_TX: begin
          if (scl_fall) begin
            if (bit_cnt != 4'd8) begin
              oe_n      = ~shreg[7];
              shreg_n   = {shreg[6:0], 1'b0};
              bit_cnt_n = bit_cnt + 4'd1;
            end else begin
              oe_n    = 1'b0;
              state_n = LS_MACK;
            end
          end
        end
        LS_MACK: begin
          if (scl_rise) begin
            mack_n = ~sda_s;
            if (!sda_s && idx != IDX_MAX) idx_n = idx + 1'b1;
          end else if (scl_fall) begin
            if (mack) begin
              state_n   = LS_TX;
              shreg_n   = {rd_data[6:0], 1'b0};
              oe_n      = ~rd_data[7];
              bit_cnt_n = 4'd1;
            end else begin
              state_n = LS_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= LS_IDLE;
      phase    <= PH_ADDR;
      bit_cnt  <= 4'd0;
      shreg    <= 8'd0;
      is_read  <= 1'b0;
      cnt      <= 8'd0;
      data_cnt <= 8'd0;
      idx      <= '0;
      oe       <= 1'b0;
      mack     <= 1'b0;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      state    <= state_n;
      phase    <= phase_n;
      bit_cnt  <= bit_cnt_n;
      shreg    <= shreg_n;
      is_read  <= is_read_n;
      cnt      <= cnt_n;
      data_cnt <= data_cnt_n;
      idx      <= idx_n;
      oe       <= oe_n;
      mack     <= mack_n;
      scl_p    <= scl_s;
      sda_p    <= sda_s;
    end
  end

  assign sda_oe  = oe;
  assign reg_idx = idx;
  assign wr_data = shreg;

  // R1
  addr_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase == PH_ADDR && shreg[7:1] != BUS_ADDR) |=> (!sda_oe && state == LS_WAIT));

  // R3
  count_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase == PH_DATA && data_cnt >= cnt) |=> (!sda_oe && state == LS_WAIT));

  // R13
  oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(!scl_s));

  // R13
  oe_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> ($past(!scl_s) || $past(start_ev) || $past(stop_ev)));

endmodule

// File: rtl/clkgen_ctrl_regs.sv
module clkgen_ctrl_regs
  import clkgen_ctrl_pkg::*;
#(
  parameter int IDXW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] reg_idx,
  input  logic [7:0]      wr_data,
  input  logic            cpu_stop_pin_n,
  input  logic            pci_stop_pin_n,
  input  logic [2:0]      fsel_pin,
  input  logic            mult_pin,
  output logic [7:0]      rd_data,
  output logic [7:0]      ctl_q [NUM_REGS],
  output logic [7:0]      div_n,
  output logic [6:0]      div_r
);

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_byte
      localparam logic [7:0] RST = reg_reset(g);
      localparam logic [7:0] WM  = reg_wmask(g);
      logic       ld;
      logic [7:0] q, d;
      assign ld = wr_en && (reg_idx == IDXW'(g));
      assign d  = (wr_data & WM) | (q & ~WM);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= RST;
        else if (ld) q <= d;
      end
      assign ctl_q[g] = q;
    end
  endgenerate

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (reg_idx == IDXW'(i)) rd_data = ctl_q[i];
    end
    if (reg_idx == IDXW'(IDX_CTL0))
      rd_data = {ctl_q[IDX_CTL0][7:5], cpu_stop_pin_n,
                 ctl_q[IDX_CTL0][3] & pci_stop_pin_n, fsel_pin};
    if (reg_idx == IDXW'(IDX_CTL1))
      rd_data = {mult_pin, ctl_q[IDX_CTL1][6:0]};
  end

  logic gate_open;
  assign gate_open = ctl_q[IDX_DIVR][0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_n <= 8'd0;
      div_r <= 7'd0;
    end else if (gate_open) begin
      div_n <= ctl_q[IDX_DIVN];
      div_r <= ctl_q[IDX_DIVR][7:1];
    end
  end

  // R10
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_open |=> ($stable(div_n) && $stable(div_r)));

endmodule

// File: rtl/clkgen_ctrl_slave.sv
module clkgen_ctrl_slave
  import clkgen_ctrl_pkg::*;
#(
  parameter logic [6:0] BUS_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2,
  parameter int         IDXW        = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic       cpu_stop_pin_n,
  input  logic       pci_stop_pin_n,
  input  logic [2:0] fsel_pin,
  input  logic       mult_pin,
  output logic       spread_en,
  output logic       spread_center,
  output logic [1:0] spread_sel,
  output logic       aux_48m_sel,
  output logic       pci_run,
  output logic [2:0] cpu_freerun,
  output logic [2:0] cpu_en,
  output logic [6:0] pci_en,
  output logic       dot48_en,
  output logic       usb48_en,
  output logic [2:0] fpci_stoppable,
  output logic [2:0] fpci_en,
  output logic [5:0] clk66_en,
  output logic [1:0] delay_sel,
  output logic [1:0] edge_slow,
  output logic [7:0] div_n,
  output logic [6:0] div_r
);

  logic [1:0]      line_s;
  logic            wr_en;
  logic [IDXW-1:0] reg_idx;
  logic [7:0]      wr_data, rd_data;
  logic [7:0]      ctl_q [NUM_REGS];

  clkgen_bus_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk (clk), .rst_n (rst_n), .din ({scl_in, sda_in}), .dout (line_s)
  );

  clkgen_smb_link #(.BUS_ADDR(BUS_ADDR), .IDXW(IDXW)) u_link (
    .clk (clk), .rst_n (rst_n), .scl_s (line_s[1]), .sda_s (line_s[0]),
    .rd_data (rd_data), .sda_oe (sda_oe), .reg_idx (reg_idx),
    .wr_en (wr_en), .wr_data (wr_data)
  );

  clkgen_ctrl_regs #(.IDXW(IDXW)) u_regs (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .reg_idx (reg_idx),
    .wr_data (wr_data), .cpu_stop_pin_n (cpu_stop_pin_n),
    .pci_stop_pin_n (pci_stop_pin_n), .fsel_pin (fsel_pin),
    .mult_pin (mult_pin), .rd_data (rd_data), .ctl_q (ctl_q),
    .div_n (div_n), .div_r (div_r)
  );

  assign spread_en      = ctl_q[0][7];
  assign aux_48m_sel    = ctl_q[0][5];
  assign pci_run        = ctl_q[0][3] & pci_stop_pin_n;
  assign cpu_freerun    = ctl_q[1][5:3];
  assign cpu_en         = ctl_q[1][2:0];
  assign pci_en         = ctl_q[2][6:0];
  assign dot48_en       = ctl_q[3][7];
  assign usb48_en       = ctl_q[3][6];
  assign fpci_stoppable = ctl_q[3][5:3];
  assign fpci_en        = ctl_q[3][2:0];
  assign spread_center  = ctl_q[4][7];
  assign clk66_en       = ctl_q[4][5:0];
  assign spread_sel     = ctl_q[5][7:6];
  assign delay_sel      = ctl_q[5][5:4];
  assign edge_slow      = {ctl_q[5][2], ctl_q[5][0]};

endmodule

// File: tb/clkgen_ctrl_slave_bench.sv
module clkgen_ctrl_slave_bench;

  localparam int Q = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line;
  logic cpu_pin = 1'b1, pci_pin = 1'b1, mult = 1'b0;
  logic [2:0] fsel = 3'b010;
  logic spread_en, spread_center, aux_48m_sel, pci_run, dot48_en, usb48_en;
  logic [1:0] spread_sel, delay_sel, edge_slow;
  logic [2:0] cpu_freerun, cpu_en, fpci_stoppable, fpci_en;
  logic [6:0] pci_en, div_r;
  logic [5:0] clk66_en;
  logic [7:0] div_n;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  clkgen_ctrl_slave u_clkgen_ctrl_slave (
    .clk (clk), .rst_n (rst_n), .scl_in (scl_m), .sda_in (sda_line), .sda_oe (sda_oe),
    .cpu_stop_pin_n (cpu_pin), .pci_stop_pin_n (pci_pin), .fsel_pin (fsel), .mult_pin (mult),
    .spread_en (spread_en), .spread_center (spread_center), .spread_sel (spread_sel),
    .aux_48m_sel (aux_48m_sel), .pci_run (pci_run), .cpu_freerun (cpu_freerun),
    .cpu_en (cpu_en), .pci_en (pci_en), .dot48_en (dot48_en), .usb48_en (usb48_en),
    .fpci_stoppable (fpci_stoppable), .fpci_en (fpci_en), .clk66_en (clk66_en),
    .delay_sel (delay_sel), .edge_slow (edge_slow), .div_n (div_n), .div_r (div_r)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [7:0] mreg [10];
  logic [7:0] work_n;
  logic [6:0] work_r;
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];
  logic       wack [16];
  logic       a_ack, c_ack, n_ack;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] wmask(int i);
    case (i)
      0: return 8'hE8;
      1: return 8'h7F;
      6: return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic void model_reset();
    mreg[0] = 8'h08; mreg[1] = 8'h07; mreg[2] = 8'h7F; mreg[3] = 8'hC7;
    mreg[4] = 8'h3F; mreg[5] = 8'h40; mreg[6] = 8'h03; mreg[7] = 8'h00;
    mreg[8] = 8'h00; mreg[9] = 8'h00;
    work_n = 8'h00; work_r = 7'h00;
  endfunction

  function automatic void model_write(int i, logic [7:0] v);
    if (i < 10) mreg[i] = (v & wmask(i)) | (mreg[i] & ~wmask(i));
    if (mreg[9][0]) begin
      work_n = mreg[8];
      work_r = mreg[9][7:1];
    end
  endfunction

  function automatic logic [7:0] model_read(int i);
    if (i == 0) return {mreg[0][7:5], cpu_pin, mreg[0][3] & pci_pin, fsel};
    if (i == 1) return {mult, mreg[1][6:0]};
    if (i < 10) return mreg[i];
    return 8'h00;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    b = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(~give_ack);
  endtask

  task automatic wr_txn(input logic [7:0] addr, input logic [7:0] cnt, input int nb);
    bus_start();
    send_byte(addr, a_ack);
    send_byte(8'($urandom), c_ack);
    send_byte(cnt, n_ack);
    for (int i = 0; i < nb; i++) send_byte(wbuf[i], wack[i]);
    bus_stop();
    if (addr == 8'hD2)
      for (int i = 0; i < nb; i++) if (i < int'(cnt)) model_write(i, wbuf[i]);
  endtask

  task automatic rd_txn(input int n);
    bus_start();
    send_byte(8'hD3, a_ack);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    bus_stop();
  endtask

  task automatic check_readback(input string req);
    rd_txn(12);
    chk({req, " read addr ack"}, a_ack, 1'b1);
    for (int i = 0; i < 12; i++) chk(req, rbuf[i], model_read(i));
  endtask

  task automatic check_outputs(input string req);
    tick(2);
    chk({req, " outputs"},
        {spread_en, aux_48m_sel, pci_run, cpu_freerun, cpu_en, pci_en, dot48_en, usb48_en,
         fpci_stoppable, fpci_en, spread_center, clk66_en, spread_sel, delay_sel, edge_slow},
        {mreg[0][7], mreg[0][5], mreg[0][3] & pci_pin, mreg[1][5:3], mreg[1][2:0], mreg[2][6:0],
         mreg[3][7], mreg[3][6], mreg[3][5:3], mreg[3][2:0], mreg[4][7], mreg[4][5:0],
         mreg[5][7:6], mreg[5][5:4], mreg[5][2], mreg[5][0]});
    chk({req, " R10 divider"}, {div_n, div_r}, {work_n, work_r});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    model_reset();
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R11 reset state, R13 line released
    chk("R11 reset sda_oe", sda_oe, 1'b0);
    check_outputs("R11 reset");
    // R4 R5 R7 R9 R11 reset readback
    check_readback("R4 reset readback");

    // R1 foreign addresses
    wbuf[0] = 8'h00;
    wr_txn(8'hA0, 8'd1, 1);
    chk("R1 addr A0 nack", a_ack, 1'b0);
    wr_txn(8'hD4, 8'd1, 1);
    chk("R1 addr D4 nack", a_ack, 1'b0);
    check_outputs("R1 no effect");

    // R2 directed write of three bytes
    wbuf[0] = 8'hB7; wbuf[1] = 8'hFF; wbuf[2] = 8'h15;
    wr_txn(8'hD2, 8'd3, 3);
    chk("R2 acks", {a_ack, c_ack, n_ack, wack[0], wack[1], wack[2]}, 6'b111111);
    check_outputs("R2 R5 R7 R8");
    check_readback("R2 R5 R7 readback");

    // R3 over count
    wbuf[0] = 8'h08; wbuf[1] = 8'h07; wbuf[2] = 8'h00; wbuf[3] = 8'h00;
    wr_txn(8'hD2, 8'd2, 4);
    chk("R3 acks", {wack[0], wack[1], wack[2], wack[3]}, 4'b1100);
    check_readback("R3 readback");

    // R9 signature ignores writes
    for (int i = 0; i < 7; i++) wbuf[i] = model_read(i);
    wbuf[0] = mreg[0]; wbuf[1] = mreg[1]; wbuf[6] = 8'hFF;
    wr_txn(8'hD2, 8'd7, 7);
    chk("R9 write acked", wack[6], 1'b1);
    check_readback("R9 readback");

    // R6 AND of pin and soft bit
    pci_pin = 1'b0;
    check_outputs("R6 pin low");
    check_readback("R6 pin low readback");
    pci_pin = 1'b1;
    wbuf[0] = 8'h00;
    wr_txn(8'hD2, 8'd1, 1);
    check_outputs("R6 soft low");
    check_readback("R6 soft low readback");

    // R5 R7 live pins
    cpu_pin = 1'b0; fsel = 3'b101; mult = 1'b1;
    check_readback("R5 R7 live pins");
    cpu_pin = 1'b1; fsel = 3'b011; mult = 1'b0;

    // R10 gate closed, then opened, then closed inside one write
    for (int i = 0; i < 10; i++) wbuf[i] = mreg[i];
    wbuf[8] = 8'hA5; wbuf[9] = {7'h33, 1'b0};
    wr_txn(8'hD2, 8'd10, 10);
    check_outputs("R10 gate closed");
    wbuf[9] = {7'h33, 1'b1};
    wr_txn(8'hD2, 8'd10, 10);
    check_outputs("R10 gate open");
    wbuf[8] = 8'h77; wbuf[9] = {7'h12, 1'b0};
    wr_txn(8'hD2, 8'd10, 10);
    check_outputs("R10 gate closing");
    chk("R10 last open copy", div_n, 8'h77);

    // R12 START in the middle of an address byte
    bus_start();
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    wbuf[0] = 8'hE0;
    wr_txn(8'hD2, 8'd1, 1);
    chk("R12 restart ack", {a_ack, wack[0]}, 2'b11);
    check_outputs("R12 restart");

    // R12 STOP in the middle of a data byte
    bus_start();
    send_byte(8'hD2, a_ack);
    send_byte(8'h00, c_ack);
    send_byte(8'd3, n_ack);
    send_byte(8'h28, wack[0]);
    put_bit(1'b0); put_bit(1'b0); put_bit(1'b0);
    bus_stop();
    model_write(0, 8'h28);
    check_readback("R12 partial byte");

    // R2 R3 R4 random writes
    for (int it = 0; it < 20; it++) begin
      int nb, cnt;
      nb  = $urandom_range(0, 11);
      cnt = $urandom_range(0, 11);
      for (int i = 0; i < nb; i++) wbuf[i] = 8'($urandom);
      pci_pin = 1'($urandom);
      fsel    = 3'($urandom);
      wr_txn(8'hD2, 8'(cnt), nb);
      chk("R2 random cmd/count ack", {a_ack, c_ack, n_ack}, 3'b111);
      for (int i = 0; i < nb; i++) chk("R3 random data ack", wack[i], (i < cnt));
      check_outputs("R8 random");
      if (it % 4 == 0) check_readback("R4 random readback");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule